// File: doc/BRIEF.md
# Calendar Date Advancer

This block keeps today's date as three registered fields: the month, the day within that month, and the weekday. When the advance input is high at a clock edge, the fields move to the following day. When it is low, they keep their values. Tomorrow's date comes from combinational logic. A lookup returns the length of the current month. The day counter wraps against that length and carries into the month. The weekday counts modulo seven on its own path, with no link to the month carry. A decoded flag shows when today is a Sunday.

The calendar has no year. February always has 28 days. A synchronous reset puts the date at the first of January and takes the starting weekday from an input. This lets the surrounding logic line the week up with the year it intends. Between resets the block moves only forward, one day at a time.

Top module: `cal_date_adv`

## Requirements
- R1: While rst_ni is low at a rising edge, the next state is month 1 (January), day 1, with the weekday taken from dow_init_i when dow_init_i is between 0 and 6. The weekday code 0 means Sunday and 6 means Saturday.
- R2: A dow_init_i value of 7 seen during reset loads weekday 0 (Sunday).
- R3: On an edge with adv_i high, if the day is below the month's length, the day goes up by one and the month stays the same. The month is 4 bits, with 1 for January and 12 for December. The day is 5 bits and starts at 1.
- R4: On an edge with adv_i high, if the day equals the month's length, the day goes back to 1 and the month goes up by one. February has 28 days. Months 4, 6, 9 and 11 have 30 days. Every other month has 31.
- R5: Advancing from month 12, day 31 gives month 1, day 1.
- R6: Each advance adds one to the weekday, and 6 goes to 0. This happens the same way whether or not the month changes.
- R7: On an edge with adv_i low and rst_ni high, the month, day and weekday all keep their values.
- R8: sunday_o is high exactly when the weekday output is 0.
- R9: Reset wins over adv_i when both are active at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| dow_init_i | input | 3 | Weekday loaded during reset |
| adv_i | input | 1 | Move to the next day at this edge |
| month_o | output | 4 | Current month, 1 to 12 |
| day_o | output | 5 | Current day of month, from 1 |
| dow_o | output | 3 | Current weekday, 0 = Sunday |
| sunday_o | output | 1 | High when today is Sunday |

## Verification
The hardest case to reach is the year rollover from December 31. The only way to get there is 364 advances from reset, and along that run every month-end carry must have come out right. The stimulus steps through a full year and one more day. It leaves short gaps with the advance low along the way, so that holding is checked on many different dates. It begins from an unusual starting weekday, so the weekday wrap and the month carries fall on unrelated cycles. A reset that lands partway through the year while the advance is high then checks that reset has priority.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int MONTH_W       = 4;
  localparam int DOM_W         = 5;
  localparam int DOW_W         = 3;
  localparam int MONTHS        = 12;
  localparam int DAYS_PER_WEEK = 7;
  localparam int LAST_DOW      = DAYS_PER_WEEK - 1;

  typedef logic [MONTH_W-1:0] month_t;
  typedef logic [DOM_W-1:0]   dom_t;
  typedef logic [DOW_W-1:0]   dow_t;

  localparam month_t M_JAN = month_t'(1);
  localparam month_t M_FEB = month_t'(2);
  localparam month_t M_APR = month_t'(4);
  localparam month_t M_JUN = month_t'(6);
  localparam month_t M_SEP = month_t'(9);
  localparam month_t M_NOV = month_t'(11);
  localparam month_t M_DEC = month_t'(MONTHS);

  localparam dom_t LEN_SHORT = dom_t'(28);
  localparam dom_t LEN_MID   = dom_t'(30);
  localparam dom_t LEN_LONG  = dom_t'(31);
  localparam dom_t DOM_FIRST = dom_t'(1);
endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  month_t month_i,
  output dom_t   len_o
);
  always_comb begin
    case (month_i)
      M_FEB:                      len_o = LEN_SHORT;
      M_APR, M_JUN, M_SEP, M_NOV: len_o = LEN_MID;
      default:                    len_o = LEN_LONG; // includes illegal codes, read as January
    endcase
  end
endmodule

// File: rtl/cal_dom_step.sv
module cal_dom_step
  import cal_pkg::*;
(
  input  month_t month_i,
  input  dom_t   dom_i,
  input  dom_t   len_i,
  output month_t month_o,
  output dom_t   dom_o
);
  logic   month_legal;
  month_t month_base;

  assign month_legal = (month_i >= M_JAN) && (month_i <= M_DEC);
  assign month_base  = month_legal ? month_i : M_JAN;

  always_comb begin
    if (dom_i >= len_i) begin
      dom_o   = DOM_FIRST;
      month_o = (month_base == M_DEC) ? M_JAN : month_base + month_t'(1);
    end else begin
      dom_o   = dom_i + dom_t'(1);
      month_o = month_base;
    end
  end
endmodule

// File: rtl/cal_dow_step.sv
module cal_dow_step
  import cal_pkg::*;
(
  input  dow_t dow_i,
  output dow_t dow_o
);
  assign dow_o = (dow_i >= dow_t'(LAST_DOW)) ? '0 : dow_i + dow_t'(1);
endmodule

// File: rtl/cal_date_adv.sv
module cal_date_adv
  import cal_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DOW_W-1:0]    dow_init_i,
  input  logic                adv_i,
  output logic [MONTH_W-1:0]  month_o,
  output logic [DOM_W-1:0]    day_o,
  output logic [DOW_W-1:0]    dow_o,
  output logic                sunday_o
);
  month_t month_q, month_nxt;
  dom_t   dom_q, dom_nxt, len;
  dow_t   dow_q, dow_nxt, dow_load;

  cal_month_len u_len (
    .month_i (month_q),
    .len_o   (len)
  );

  cal_dom_step u_dom (
    .month_i (month_q),
    .dom_i   (dom_q),
    .len_i   (len),
    .month_o (month_nxt),
    .dom_o   (dom_nxt)
  );

  cal_dow_step u_dow (
    .dow_i (dow_q),
    .dow_o (dow_nxt)
  );

  // out-of-week code loads as Sunday
  assign dow_load = (dow_init_i > dow_t'(LAST_DOW)) ? '0 : dow_init_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      month_q <= M_JAN;
      dom_q   <= DOM_FIRST;
      dow_q   <= dow_load;
    end else if (adv_i) begin
      month_q <= month_nxt;
      dom_q   <= dom_nxt;
      dow_q   <= dow_nxt;
    end
  end

  assign month_o  = month_q;
  assign day_o    = dom_q;
  assign dow_o    = dow_q;
  assign sunday_o = (dow_q == '0);

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(month_q) && $stable(dom_q) && $stable(dow_q)); // R7
  AST_DOW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && dow_q == dow_t'(LAST_DOW) |=> dow_q == '0); // R6
  AST_SUNDAY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && dow_q == dow_t'(LAST_DOW) |=> sunday_o); // R8
  AST_SUNDAY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && dow_q != dow_t'(LAST_DOW) |=> !sunday_o); // R8
  AST_YEAR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && month_q == M_DEC && dom_q == LEN_LONG |=> month_q == M_JAN && dom_q == DOM_FIRST); // R5
  AST_FEB_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && month_q == M_FEB && dom_q == LEN_SHORT |=> month_q == month_t'(3) && dom_q == DOM_FIRST); // R4
  AST_DATE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (month_q >= M_JAN && month_q <= M_DEC && dom_q >= DOM_FIRST && dom_q <= LEN_LONG)); // R3
endmodule

// File: tb/cal_date_adv_tb.sv
module cal_date_adv_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] dow_init_i = 3'd0;
  logic       adv_i = 1'b0;
  logic [3:0] month_o;
  logic [4:0] day_o;
  logic [2:0] dow_o;
  logic       sunday_o;

  int total = 0;
  int bad = 0;
  int m_mon = 1, m_day = 1, m_dow = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cal_date_adv dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dow_init_i (dow_init_i),
    .adv_i      (adv_i),
    .month_o    (month_o),
    .day_o      (day_o),
    .dow_o      (dow_o),
    .sunday_o   (sunday_o)
  );

  function automatic int mlen(int mon);
    if (mon == 2) return 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // called at a negedge: drive, take the edge, compare at the next negedge
  task automatic cyc(bit rst, bit adv, int init, string tag);
    string dtag, wtag;
    rst_ni = !rst;
    adv_i = adv;
    dow_init_i = init[2:0];
    @(posedge clk_i);
    if (rst) begin
      m_mon = 1; m_day = 1; m_dow = (init > 6) ? 0 : init;
      dtag = tag; wtag = tag;
    end else if (adv) begin
      if (m_mon == 12 && m_day == 31) dtag = "R5";
      else if (m_day == mlen(m_mon)) dtag = "R4";
      else dtag = "R3";
      wtag = "R6";
      m_dow = (m_dow + 1) % 7;
      m_day++;
      if (m_day > mlen(m_mon)) begin
        m_day = 1;
        m_mon = (m_mon == 12) ? 1 : m_mon + 1;
      end
    end else begin
      dtag = "R7"; wtag = "R7";
    end
    @(negedge clk_i);
    chk(dtag, "month", int'(month_o), m_mon);
    chk(dtag, "day", int'(day_o), m_day);
    chk(wtag, "dow", int'(dow_o), m_dow);
    chk("R8", "sunday", int'(sunday_o), (m_dow == 0) ? 1 : 0);
  endtask

  initial begin
    @(negedge clk_i);
    cyc(1, 0, 3, "R1");
    cyc(1, 0, 3, "R1");
    cyc(0, 0, 0, "R7");
    cyc(1, 1, 7, "R2");       // also R9: adv high under reset
    cyc(1, 0, 0, "R1");
    cyc(1, 1, 5, "R9");
    // full year plus one day from a Friday start, with idle gaps
    for (int i = 0; i < 366; i++) begin
      cyc(0, 1, 0, "R3");
      if (i % 23 == 7) begin
        cyc(0, 0, 0, "R7");
        cyc(0, 0, 0, "R7");
      end
    end
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, "R3");
    cyc(1, 1, 6, "R9");
    cyc(0, 1, 0, "R6");
    cyc(0, 0, 0, "R7");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule